// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block sits in front of a timer counter and decides, cycle by cycle, whether the counter advances, which way it counts, and when it is restarted or started. It chooses one trigger source from a set of candidates: three internal trigger lines, a pulse on every edge of channel 1, the channel 1 level, the channel 2 level, and an external input that can be inverted. The chosen trigger then drives one of eight slave behaviours. These are free running, three quadrature encoder variants, restart on a trigger edge, gating by the trigger level, start on a trigger edge, and clocking from the trigger's rising edges.

The external input has a second role as a clock source. When that role is enabled, its active edges go through a divide-by-1/2/4/8 prescaler and replace the internal clock as the count enable in the modes that would otherwise count every cycle. An optional synchronisation delay holds every trigger effect back by one cycle, so that timers slaved to this one's trigger output act in the same cycle as this one. A sticky trigger flag records trigger events and software trigger requests.

Top module: `trig_slave_ctrl`

## Requirements
- R1: A synchronous reset drives all outputs to 0 and clears the flag, the run latch, the prescaler and the edge history. All outputs are registered and reflect the inputs sampled at the preceding rising clock edge.
- R2: With slave mode 0 and external clock off, `tick_o` equals `cnt_en_i` from the previous edge. The channel, trigger and external inputs have no effect on any output.
- R3: When `ext_clk2_i` is 1, each active external edge is counted. An active edge is a rising edge, or a falling edge when `ext_inv_i` is 1. In modes 0, 4, 5 and 6, one tick is produced per 2^`ext_div_i` active edges, on the last edge of each group. The prescaler restarts whenever `ext_clk2_i` is 0.
- R4: `trig_sel_i` picks the trigger as follows: 0, 1 and 2 pick `itrig_i[0..2]`; 3 is constant low; 4 is a one-cycle pulse on any `ch1_i` change; 5 is `ch1_i`; 6 is `ch2_i`; 7 is `ext_i` after the polarity inversion.
- R5: The encoder modes work as follows. Mode 1 counts on `ch1_i` edges only. Mode 2 counts on `ch2_i` edges only. Mode 3 counts on edges of both channels. A `ch1_i` edge counts up when the new `ch1_i` differs from `ch2_i`. A `ch2_i` edge counts up when the new `ch2_i` equals `ch1_i`. A cycle in which both channels change does not count. `dir_down_o` holds the last step direction and is 0 outside the encoder modes.
- R6: In mode 4, a rising trigger edge gives a one-cycle `cnt_reset_o` pulse, which both reinitialises the counter and updates its registers. Counting continues from the internal clock.
- R7: In mode 5, `tick_o` is 1 only while the trigger is high and `cnt_en_i` is 1. A falling trigger stops counting without any reset pulse.
- R8: In mode 6, a rising trigger edge gives a one-cycle `cnt_start_o` pulse and sets a run latch. The block then counts every cycle even with `cnt_en_i` at 0, until the mode changes or a reset occurs.
- R9: In mode 7, `tick_o` pulses once for each rising edge of the trigger while `cnt_en_i` is 1.
- R10: `trig_flag_o` is set by a trigger event or by `sw_trig_i`, and cleared by `flag_clr_i`. A set wins over a clear in the same cycle. A trigger event is a rising edge in modes 4, 6 and 7, or either edge in mode 5. Modes 0 to 3 produce no trigger events.
- R11: With `sync_dly_i` at 1, every trigger-driven output effect appears exactly one cycle later than with `sync_dly_i` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| itrig_i | input | N_ITRIG | Internal trigger lines |
| ch1_i | input | 1 | Filtered channel 1 level |
| ch2_i | input | 1 | Filtered channel 2 level |
| ext_i | input | 1 | External trigger input |
| trig_sel_i | input | 3 | Trigger source select |
| slave_mode_i | input | 3 | Slave behaviour select |
| ext_inv_i | input | 1 | Invert external input |
| ext_div_i | input | EXT_DIV_W | External prescaler code (divide by 2^code) |
| ext_clk2_i | input | 1 | Count from prescaled external edges |
| sync_dly_i | input | 1 | Delay trigger effects by one cycle |
| cnt_en_i | input | 1 | Software counter enable |
| sw_trig_i | input | 1 | Software trigger request |
| flag_clr_i | input | 1 | Clear trigger flag |
| tick_o | output | 1 | Counter advances this cycle |
| dir_down_o | output | 1 | Count direction, 1 = down |
| cnt_reset_o | output | 1 | Reinitialise counter and update registers |
| cnt_start_o | output | 1 | Counter start pulse |
| trig_flag_o | output | 1 | Sticky trigger flag |

## Verification
The bench builds the block with its defaults: three internal triggers and a 2-bit external prescaler code. These defaults make every trigger-select code reachable, including the unused code 3, and all four divide ratios up to eight edges per tick. Because the selected source can be every one of the eight codes, each encoder variant and each of the edge-driven modes can be exercised with and without the one-cycle synchronisation delay.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 3;
    localparam int NSRC   = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_IT0      = 3'd0,
        SRC_IT1      = 3'd1,
        SRC_IT2      = 3'd2,
        SRC_NONE     = 3'd3,
        SRC_CH1_EDGE = 3'd4,
        SRC_CH1      = 3'd5,
        SRC_CH2      = 3'd6,
        SRC_EXT      = 3'd7
    } trig_src_e;

    typedef enum logic [MODE_W-1:0] {
        SM_FREE    = 3'd0,
        SM_QUAD_A  = 3'd1,
        SM_QUAD_B  = 3'd2,
        SM_QUAD_AB = 3'd3,
        SM_RESTART = 3'd4,
        SM_GATE    = 3'd5,
        SM_START   = 3'd6,
        SM_EXTCLK  = 3'd7
    } slave_mode_e;

    typedef struct packed {
        logic valid;
        logic down;
    } quad_step_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } trig_state_t;

    function automatic logic is_quad(slave_mode_e m);
        return (m == SM_QUAD_A) || (m == SM_QUAD_B) || (m == SM_QUAD_AB);
    endfunction

    // Quadrature step from the current and previous channel levels.
    function automatic quad_step_t quad_decode(slave_mode_e m, logic a_now, logic a_old,
                                               logic b_now, logic b_old);
        quad_step_t r;
        logic a_chg;
        logic b_chg;
        a_chg = a_now ^ a_old;
        b_chg = b_now ^ b_old;
        r = '0;
        if (a_chg && !b_chg && (m == SM_QUAD_A || m == SM_QUAD_AB)) begin
            r.valid = 1'b1;
            r.down  = (a_now == b_now);
        end else if (b_chg && !a_chg && (m == SM_QUAD_B || m == SM_QUAD_AB)) begin
            r.valid = 1'b1;
            r.down  = (b_now != a_now);
        end
        return r;
    endfunction

endpackage

// File: rtl/tsc_ext_path.sv
module tsc_ext_path #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_i,
    input  logic             inv_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             clk2_en_i,
    output logic             lvl_o,
    output logic             tick_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic             pol;
    logic             pol_q;
    logic             rise;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   term;

    assign pol  = ext_i ^ inv_i;
    assign rise = pol & ~pol_q;
    assign term = ({{CNT_W{1'b0}}, 1'b1} << div_i) - {{CNT_W{1'b0}}, 1'b1};
    assign wrap = ({1'b0, cnt_q} >= term);

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pol_q <= pol;
            if (!clk2_en_i) begin
                cnt_q <= '0;
            end else if (rise) begin
                cnt_q <= wrap ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
    end

    assign lvl_o  = pol;
    assign tick_o = clk2_en_i & rise & wrap;

    AST_EXT_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o); // R3

endmodule

// File: rtl/tsc_trig_select.sv
module tsc_trig_select
    import tsc_pkg::*;
#(
    parameter int N_IT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IT-1:0]   itrig_i,
    input  logic              ch1_edge_i,
    input  logic              ch1_i,
    input  logic              ch2_i,
    input  logic              ext_lvl_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              sync_dly_i,
    output trig_state_t       trig_o
);
    logic [NSRC-1:0] src;
    logic            raw;
    logic            raw_q;
    logic            lvl;
    logic            lvl_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g < N_IT) begin : g_it
            assign src[g] = itrig_i[g];
        end else if (g == int'(SRC_CH1_EDGE)) begin : g_edge
            assign src[g] = ch1_edge_i;
        end else if (g == int'(SRC_CH1)) begin : g_c1
            assign src[g] = ch1_i;
        end else if (g == int'(SRC_CH2)) begin : g_c2
            assign src[g] = ch2_i;
        end else if (g == int'(SRC_EXT)) begin : g_ext
            assign src[g] = ext_lvl_i;
        end else begin : g_none
            assign src[g] = 1'b0;
        end
    end

    assign raw = src[sel_i];
    assign lvl = sync_dly_i ? raw_q : raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            lvl_q <= 1'b0;
        end else begin
            raw_q <= raw;
            lvl_q <= lvl;
        end
    end

    assign trig_o.lvl  = lvl;
    assign trig_o.rise = lvl & ~lvl_q;
    assign trig_o.fall = ~lvl & lvl_q;

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        trig_o.rise |=> !trig_o.rise); // R4

endmodule

// File: rtl/tsc_quad.sv
module tsc_quad
    import tsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ch1_i,
    input  logic        ch2_i,
    input  slave_mode_e mode_i,
    output quad_step_t  step_o,
    output logic        ch1_edge_o
);
    logic a_q;
    logic b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= ch1_i;
            b_q <= ch2_i;
        end
    end

    assign step_o     = quad_decode(mode_i, ch1_i, a_q, ch2_i, b_q);
    assign ch1_edge_o = ch1_i ^ a_q;

    AST_QUAD_ONLY_IN_ENC: assert property (@(posedge clk) disable iff (rst)
        step_o.valid |-> is_quad(mode_i)); // R5
    AST_QUAD_A_IGNORES_CH2: assert property (@(posedge clk) disable iff (rst)
        (step_o.valid && mode_i == SM_QUAD_A) |-> (ch2_i == b_q)); // R5

endmodule

// File: rtl/trig_slave_ctrl.sv
module trig_slave_ctrl
    import tsc_pkg::*;
#(
    parameter int N_ITRIG   = 3,
    parameter int EXT_DIV_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ITRIG-1:0]   itrig_i,
    input  logic                 ch1_i,
    input  logic                 ch2_i,
    input  logic                 ext_i,
    input  logic [2:0]           trig_sel_i,
    input  logic [2:0]           slave_mode_i,
    input  logic                 ext_inv_i,
    input  logic [EXT_DIV_W-1:0] ext_div_i,
    input  logic                 ext_clk2_i,
    input  logic                 sync_dly_i,
    input  logic                 cnt_en_i,
    input  logic                 sw_trig_i,
    input  logic                 flag_clr_i,
    output logic                 tick_o,
    output logic                 dir_down_o,
    output logic                 cnt_reset_o,
    output logic                 cnt_start_o,
    output logic                 trig_flag_o
);
    slave_mode_e mode;
    quad_step_t  step;
    trig_state_t trig;
    logic        ch1_edge;
    logic        ext_lvl;
    logic        ext_tick;
    logic        base;
    logic        evt;
    logic        tick_n;
    logic        rst_n;
    logic        start_n;
    logic        run_n;
    logic        run_q;
    logic        dir_n;

    assign mode = slave_mode_e'(slave_mode_i);

    tsc_quad u_quad (
        .clk        (clk),
        .rst        (rst),
        .ch1_i      (ch1_i),
        .ch2_i      (ch2_i),
        .mode_i     (mode),
        .step_o     (step),
        .ch1_edge_o (ch1_edge)
    );

    tsc_ext_path #(.DIV_W(EXT_DIV_W)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .ext_i     (ext_i),
        .inv_i     (ext_inv_i),
        .div_i     (ext_div_i),
        .clk2_en_i (ext_clk2_i),
        .lvl_o     (ext_lvl),
        .tick_o    (ext_tick)
    );

    tsc_trig_select #(.N_IT(N_ITRIG)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .itrig_i    (itrig_i),
        .ch1_edge_i (ch1_edge),
        .ch1_i      (ch1_i),
        .ch2_i      (ch2_i),
        .ext_lvl_i  (ext_lvl),
        .sel_i      (trig_sel_i),
        .sync_dly_i (sync_dly_i),
        .trig_o     (trig)
    );

    assign base = ext_clk2_i ? ext_tick : 1'b1;

    always_comb begin
        tick_n  = 1'b0;
        rst_n   = 1'b0;
        start_n = 1'b0;
        evt     = 1'b0;
        run_n   = 1'b0;
        unique case (mode)
            SM_FREE: begin
                tick_n = cnt_en_i & base;
            end
            SM_QUAD_A, SM_QUAD_B, SM_QUAD_AB: begin
                tick_n = cnt_en_i & step.valid;
            end
            SM_RESTART: begin
                tick_n = cnt_en_i & base;
                rst_n  = trig.rise;
                evt    = trig.rise;
            end
            SM_GATE: begin
                tick_n = cnt_en_i & base & trig.lvl;
                evt    = trig.rise | trig.fall;
            end
            SM_START: begin
                tick_n  = (cnt_en_i | run_q | trig.rise) & base;
                start_n = trig.rise;
                evt     = trig.rise;
                run_n   = run_q | trig.rise;
            end
            SM_EXTCLK: begin
                tick_n = cnt_en_i & trig.rise;
                evt    = trig.rise;
            end
            default: begin
                tick_n = 1'b0;
            end
        endcase
        if (is_quad(mode)) begin
            dir_n = step.valid ? step.down : dir_down_o;
        end else begin
            dir_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_o      <= 1'b0;
            dir_down_o  <= 1'b0;
            cnt_reset_o <= 1'b0;
            cnt_start_o <= 1'b0;
            trig_flag_o <= 1'b0;
            run_q       <= 1'b0;
        end else begin
            tick_o      <= tick_n;
            dir_down_o  <= dir_n;
            cnt_reset_o <= rst_n;
            cnt_start_o <= start_n;
            run_q       <= run_n;
            if (evt || sw_trig_i) begin
                trig_flag_o <= 1'b1;
            end else if (flag_clr_i) begin
                trig_flag_o <= 1'b0;
            end
        end
    end

    AST_RESET_PULSE_MODE: assert property (@(posedge clk) disable iff (rst)
        cnt_reset_o |-> ($past(slave_mode_i) == 3'd4)); // R6
    AST_START_PULSE_MODE: assert property (@(posedge clk) disable iff (rst)
        cnt_start_o |-> ($past(slave_mode_i) == 3'd6)); // R8
    AST_SW_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        sw_trig_i |=> trig_flag_o); // R10
    AST_GATE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (tick_o && $past(slave_mode_i) == 3'd5) |-> $past(trig.lvl)); // R7
    AST_DIR_ONLY_ENCODER: assert property (@(posedge clk) disable iff (rst)
        dir_down_o |-> ($past(slave_mode_i) inside {3'd1, 3'd2, 3'd3})); // R5

endmodule

// File: tb/trig_slave_ctrl_bench.sv
module trig_slave_ctrl_bench;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] sel;
        logic [2:0] itr;
        logic [5:0] in;   // {ch1, ch2, ext, cnt_en, sw_trig, flag_clr}
        logic [4:0] exp;  // {tick, dir, reset, start, flag}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TABLE [NV] = '{
        '{3'd5, 3'd0, 3'b000, 6'b000100, 5'b00000, 4'd7},  // R7 gated, low
        '{3'd5, 3'd0, 3'b001, 6'b000100, 5'b10001, 4'd7},  // R7 rising opens gate
        '{3'd5, 3'd0, 3'b001, 6'b000101, 5'b10000, 4'd10}, // R10 clear
        '{3'd5, 3'd0, 3'b000, 6'b000100, 5'b00001, 4'd10}, // R10 falling edge sets flag
        '{3'd5, 3'd0, 3'b000, 6'b000101, 5'b00000, 4'd7},  // R7 closed, no reset
        '{3'd4, 3'd1, 3'b000, 6'b000100, 5'b10000, 4'd6},  // R6 internal clock
        '{3'd4, 3'd1, 3'b010, 6'b000100, 5'b10101, 4'd6},  // R6 reset pulse
        '{3'd4, 3'd1, 3'b010, 6'b000101, 5'b10000, 4'd6},  // R6 single pulse
        '{3'd4, 3'd1, 3'b000, 6'b000000, 5'b00000, 4'd6},  // R6 falling ignored
        '{3'd7, 3'd2, 3'b000, 6'b000100, 5'b00000, 4'd9},  // R9 idle
        '{3'd7, 3'd2, 3'b100, 6'b000100, 5'b10001, 4'd9},  // R9 edge tick
        '{3'd7, 3'd2, 3'b100, 6'b000100, 5'b00001, 4'd9},  // R9 level no tick
        '{3'd7, 3'd2, 3'b000, 6'b000100, 5'b00001, 4'd9},  // R9 falling no tick
        '{3'd7, 3'd2, 3'b100, 6'b000101, 5'b10001, 4'd10}, // R10 set wins over clear
        '{3'd7, 3'd2, 3'b000, 6'b000101, 5'b00000, 4'd10}, // R10 clear
        '{3'd6, 3'd5, 3'b000, 6'b000000, 5'b00000, 4'd8},  // R8 waiting
        '{3'd6, 3'd5, 3'b000, 6'b100000, 5'b10011, 4'd8},  // R8 start pulse
        '{3'd6, 3'd5, 3'b000, 6'b000001, 5'b10000, 4'd8},  // R8 keeps running
        '{3'd0, 3'd5, 3'b000, 6'b000000, 5'b00000, 4'd8},  // R8 run ends on mode change
        '{3'd7, 3'd3, 3'b111, 6'b111100, 5'b00000, 4'd4},  // R4 code 3 constant low
        '{3'd7, 3'd7, 3'b111, 6'b111100, 5'b10001, 4'd4},  // R4 external level
        '{3'd7, 3'd6, 3'b111, 6'b111101, 5'b00000, 4'd4},  // R4 ch2 level, no edge
        '{3'd0, 3'd0, 3'b000, 6'b000110, 5'b10001, 4'd2},  // R2 free run, sw trigger
        '{3'd0, 3'd0, 3'b000, 6'b000001, 5'b00000, 4'd2}   // R2 enable low
    };

    logic       clk;
    logic       rst;
    logic [2:0] itrig;
    logic       ch1, ch2, ext, ext_inv, ext_clk2, sync_dly, cnt_en, sw_trig, flag_clr;
    logic [2:0] sel, mode;
    logic [1:0] ext_div;
    logic       tick, dir_down, cnt_reset, cnt_start, trig_flag;

    int n_chk = 0;
    int n_err = 0;

    trig_slave_ctrl u_trig_slave_ctrl (
        .clk          (clk),
        .rst          (rst),
        .itrig_i      (itrig),
        .ch1_i        (ch1),
        .ch2_i        (ch2),
        .ext_i        (ext),
        .trig_sel_i   (sel),
        .slave_mode_i (mode),
        .ext_inv_i    (ext_inv),
        .ext_div_i    (ext_div),
        .ext_clk2_i   (ext_clk2),
        .sync_dly_i   (sync_dly),
        .cnt_en_i     (cnt_en),
        .sw_trig_i    (sw_trig),
        .flag_clr_i   (flag_clr),
        .tick_o       (tick),
        .dir_down_o   (dir_down),
        .cnt_reset_o  (cnt_reset),
        .cnt_start_o  (cnt_start),
        .trig_flag_o  (trig_flag)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [4:0] e);
        chk(req, "tick",  tick,      e[4]);
        chk(req, "dir",   dir_down,  e[3]);
        chk(req, "reset", cnt_reset, e[2]);
        chk(req, "start", cnt_start, e[1]);
        chk(req, "flag",  trig_flag, e[0]);
    endtask

    // Inputs are set 5 ns after a rising edge; outputs sampled 5 ns after the next.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic enc(input logic [2:0] m, input logic a, input logic b,
                       input logic e_tick, input logic e_dir);
        mode = m; ch1 = a; ch2 = b;
        step();
        chk("R5", "tick", tick, e_tick);
        chk("R5", "dir", dir_down, e_dir);
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; itrig = '0; ch1 = 0; ch2 = 0; ext = 0; ext_inv = 0; ext_clk2 = 0;
        sync_dly = 0; cnt_en = 0; sw_trig = 0; flag_clr = 0; sel = '0; mode = '0; ext_div = '0;
        repeat (3) @(posedge clk);
        #5;
        chk_all("R1", 5'b00000);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            mode = TABLE[i].mode;
            sel  = TABLE[i].sel;
            itrig = TABLE[i].itr;
            {ch1, ch2, ext, cnt_en, sw_trig, flag_clr} = TABLE[i].in;
            step();
            chk_all($sformatf("R%0d", TABLE[i].req), TABLE[i].exp);
        end
        sw_trig = 0; flag_clr = 0;

        // R5 encoder sequences
        cnt_en = 1; sel = 3'd0; itrig = '0;
        enc(3'd3, 0, 0, 0, 0);
        enc(3'd3, 1, 0, 1, 0);
        enc(3'd3, 1, 1, 1, 0);
        enc(3'd3, 0, 1, 1, 0);
        enc(3'd3, 0, 0, 1, 0);
        enc(3'd3, 0, 1, 1, 1);
        enc(3'd3, 0, 1, 0, 1);
        enc(3'd1, 0, 0, 0, 1);
        enc(3'd1, 1, 0, 1, 0);
        enc(3'd2, 1, 1, 1, 0);
        enc(3'd2, 0, 1, 0, 0);
        enc(3'd3, 1, 0, 0, 0);
        ch1 = 0; ch2 = 0; mode = 3'd0; cnt_en = 0;
        step();

        // R3 prescaled external clock, all divide ratios
        for (int d = 0; d < 4; d++) begin
            ext_clk2 = 0; ext = 0; ext_div = 2'(d); cnt_en = 1;
            step();
            ext_clk2 = 1;
            step();
            for (int k = 1; k <= 8; k++) begin
                ext = 1;
                step();
                chk("R3", $sformatf("tick div%0d edge%0d", d, k), tick, (k % (1 << d)) == 0);
                ext = 0;
                step();
                chk("R3", "tick between edges", tick, 1'b0);
            end
        end
        // R3 inverted polarity: falling edges are active
        ext_clk2 = 0; ext_div = 2'd0;
        step();
        ext_inv = 1; ext = 1; ext_clk2 = 1;
        step();
        chk("R3", "inverted idle", tick, 1'b0);
        ext = 0;
        step();
        chk("R3", "inverted falling edge", tick, 1'b1);
        ext = 1;
        step();
        chk("R3", "inverted rising edge", tick, 1'b0);
        ext_clk2 = 0; ext_inv = 0; ext = 0; cnt_en = 0;
        step();

        // R11 synchronisation delay, clock mode 7
        mode = 3'd7; sel = 3'd0; cnt_en = 1; sync_dly = 1; flag_clr = 1;
        step(); step();
        flag_clr = 0; itrig = 3'b001;
        step();
        chk("R11", "tick held back", tick, 1'b0);
        chk("R11", "flag held back", trig_flag, 1'b0);
        step();
        chk("R11", "tick delayed", tick, 1'b1);
        chk("R11", "flag delayed", trig_flag, 1'b1);
        // R11 delay in restart mode
        mode = 3'd4; sel = 3'd1; itrig = 3'b000;
        step(); step();
        itrig = 3'b010;
        step();
        chk("R11", "reset held back", cnt_reset, 1'b0);
        step();
        chk("R11", "reset delayed", cnt_reset, 1'b1);
        sync_dly = 0; itrig = '0;
        step(); step();

        // R4 channel 1 edge pulse source in clock mode 7
        mode = 3'd7; sel = 3'd4; ch1 = 0;
        step(); step();
        ch1 = 1;
        step();
        chk("R4", "edge pulse rise", tick, 1'b1);
        step();
        chk("R4", "edge pulse steady", tick, 1'b0);
        ch1 = 0;
        step();
        chk("R4", "edge pulse fall", tick, 1'b1);

        // R1 reset in mid-run clears the flag
        sw_trig = 1;
        step();
        sw_trig = 0; rst = 1;
        step();
        chk_all("R1", 5'b00000);
        rst = 0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule